// File: doc/BRIEF.md
# Two-Channel Result Limit Monitor with Shared Alert Pin

This block watches each conversion result that an analog-to-digital converter delivers and checks it against a window. Each channel has its own window, made of a high bound and a low bound. A result that leaves its channel's window sets a sticky status flag for that side and channel. Software can route those flags to an active-low, open-drain style pin that serves as an interrupt. The same pin can instead show the converter's busy state, selected by a control bit.

Each channel also carries a hysteresis value. Once a side has tripped, it stays tripped until a result comes back inside the window by at least the hysteresis margin. While a side is tripped, further out-of-range results do not set its flag again after software has cleared it. This prevents a stream of interrupts from a signal that hovers near a bound.

Results are unsigned 12-bit codes. Configuration arrives on a simple write port; decoding a register map onto that port is left to the surrounding logic.

Top module: `limit_alert_mon`

## Requirements
- R1: After reset, every status flag is 0 and `alert_n` is 1. Each channel's high bound is 0xFFF, its low bound is 0x000 and its hysteresis is 0. The alert is disabled and the pin is in alert mode, so results 0x000 and 0xFFF set no flag.
- R2: A valid result on channel c that is strictly greater than that channel's high bound sets `stat_hi[c]` at the clock edge that takes the result, unless the high side of c is already tripped. A result equal to the bound sets nothing.
- R3: A valid result on channel c that is strictly less than that channel's low bound sets `stat_lo[c]` at that edge, unless the low side of c is already tripped. A result equal to the bound sets nothing.
- R4: Bounds, hysteresis and flags are kept per channel. A result or a write on one channel never changes the flags of another channel.
- R5: The high side of a channel trips on any result above its high bound. It re-arms only on a result at or below (high bound − hysteresis). A result between that threshold and the bound leaves it tripped.
- R6: The low side of a channel trips on any result below its low bound. It re-arms only on a result at or above (low bound + hysteresis).
- R7: The write port uses `wr_sel` 3'd0 for the high bound, 3'd1 for the low bound and 3'd2 for hysteresis; these three take `wr_data` for channel `wr_chan`. With `wr_sel` 3'd3, `wr_data[0]` is the alert enable and `wr_data[1]` selects busy mode. With `wr_sel` 3'd4, `wr_data[0]`=1 clears `stat_hi[wr_chan]` and `wr_data[1]`=1 clears `stat_lo[wr_chan]`. A flag that is being set and cleared in the same cycle ends set.
- R8: In alert mode, `alert_n` is 0 exactly when the alert is enabled and at least one status flag is 1. Flags still record events while the alert is disabled.
- R9: In busy mode, `alert_n` is the inverse of `busy_in`, whatever the flags hold.
- R10: The re-arm thresholds saturate. If the high bound minus the hysteresis is below zero, the threshold is 0x000. If the low bound plus the hysteresis exceeds 0xFFF, the threshold is 0xFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result strobe |
| res_chan | input | 1 | Channel index of the result |
| res_data | input | 12 | Unsigned conversion result |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target (see R7) |
| wr_chan | input | 1 | Channel addressed by the write |
| wr_data | input | 12 | Write value |
| busy_in | input | 1 | Converter busy indication |
| alert_n | output | 1 | Active-low shared alert/busy pin |
| stat_hi | output | 2 | Sticky high-side flags, one per channel |
| stat_lo | output | 2 | Sticky low-side flags, one per channel |

## Verification
A wrong trip state stays hidden until software clears a flag. It then shows up on the next out-of-range result, either as a flag that comes back when it should not or as one that never returns, at the edge that takes that result. For this reason the bench clears a flag and then walks each side through the hysteresis band one result at a time. A wrong bound, a swapped channel or a broken set/clear priority shows on the flags and on `alert_n` one cycle after the offending input. The reference model compares these outputs after every edge.

// File: rtl/limit_alert_mon.sv
module limit_alert_mon #(
  parameter int W   = 12,
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           res_valid,
  input  logic [CW-1:0]  res_chan,
  input  logic [W-1:0]   res_data,
  input  logic           wr_en,
  input  logic [2:0]     wr_sel,
  input  logic [CW-1:0]  wr_chan,
  input  logic [W-1:0]   wr_data,
  input  logic           busy_in,
  output logic           alert_n,
  output logic [NCH-1:0] stat_hi,
  output logic [NCH-1:0] stat_lo
);

  localparam logic [2:0] SEL_HI  = 3'd0;
  localparam logic [2:0] SEL_LO  = 3'd1;
  localparam logic [2:0] SEL_HYS = 3'd2;
  localparam logic [2:0] SEL_CTL = 3'd3;
  localparam logic [2:0] SEL_CLR = 3'd4;

  logic en_q, bsel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      bsel_q <= 1'b0;
    end else if (wr_en && wr_sel == SEL_CTL) begin
      en_q   <= wr_data[0];
      bsel_q <= wr_data[1];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [W-1:0] hi_q, lo_q, hy_q;
    logic         trip_hi, trip_lo, sh_q, sl_q;
    logic [W:0]   hdiff, lsum;
    logic [W-1:0] thr_hi, thr_lo;
    logic         hit, wsel, over, under, clr_h, clr_l;

    assign hit    = res_valid && res_chan == CW'(c);
    assign wsel   = wr_en && wr_chan == CW'(c);
    assign over   = hit && res_data > hi_q;
    assign under  = hit && res_data < lo_q;
    assign clr_h  = wsel && wr_sel == SEL_CLR && wr_data[0];
    assign clr_l  = wsel && wr_sel == SEL_CLR && wr_data[1];
    assign hdiff  = {1'b0, hi_q} - {1'b0, hy_q};
    assign lsum   = {1'b0, lo_q} + {1'b0, hy_q};
    assign thr_hi = hdiff[W] ? '0 : hdiff[W-1:0];
    assign thr_lo = lsum[W]  ? '1 : lsum[W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q    <= '1;
        lo_q    <= '0;
        hy_q    <= '0;
        trip_hi <= 1'b0;
        trip_lo <= 1'b0;
        sh_q    <= 1'b0;
        sl_q    <= 1'b0;
      end else begin
        if (wsel && wr_sel == SEL_HI)  hi_q <= wr_data;
        if (wsel && wr_sel == SEL_LO)  lo_q <= wr_data;
        if (wsel && wr_sel == SEL_HYS) hy_q <= wr_data;

        if (over)                              trip_hi <= 1'b1;
        else if (hit && res_data <= thr_hi)    trip_hi <= 1'b0;
        if (under)                             trip_lo <= 1'b1;
        else if (hit && res_data >= thr_lo)    trip_lo <= 1'b0;

        if (over && !trip_hi)   sh_q <= 1'b1;
        else if (clr_h)         sh_q <= 1'b0;
        if (under && !trip_lo)  sl_q <= 1'b1;
        else if (clr_l)         sl_q <= 1'b0;
      end
    end

    assign stat_hi[c] = sh_q;
    assign stat_lo[c] = sl_q;
  end

  assign alert_n = bsel_q ? ~busy_in : ~(en_q && |(stat_hi | stat_lo));

endmodule

// File: rtl/limit_alert_mon_chk.sv
module limit_alert_mon_chk #(
  parameter int W   = 12,
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           res_valid,
  input logic [CW-1:0]  res_chan,
  input logic           wr_en,
  input logic [2:0]     wr_sel,
  input logic [CW-1:0]  wr_chan,
  input logic           busy_in,
  input logic           alert_n,
  input logic [NCH-1:0] stat_hi,
  input logic [NCH-1:0] stat_lo
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (stat_hi == '0 && stat_lo == '0 && alert_n));

  // R8
  idle_pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_hi == '0 && stat_lo == '0 && !busy_in) |-> alert_n);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R2
    hi_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_hi[c]) |-> $past(res_valid && res_chan == CW'(c)));
    // R3
    lo_set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_lo[c]) |-> $past(res_valid && res_chan == CW'(c)));
    // R7
    hi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_hi[c]) |-> $past(wr_en && wr_sel == 3'd4 && wr_chan == CW'(c)));
    // R7
    lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat_lo[c]) |-> $past(wr_en && wr_sel == 3'd4 && wr_chan == CW'(c)));
  end

endmodule

bind limit_alert_mon limit_alert_mon_chk #(.W(W), .NCH(NCH)) u_chk (.*);

// File: tb/limit_alert_mon_tb.sv
module limit_alert_mon_tb;
  logic        clk = 0, rst_n = 0;
  logic        res_valid = 0, wr_en = 0, busy_in = 0;
  logic [0:0]  res_chan = 0, wr_chan = 0;
  logic [11:0] res_data = 0, wr_data = 0;
  logic [2:0]  wr_sel = 0;
  logic        alert_n;
  logic [1:0]  stat_hi, stat_lo;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  limit_alert_mon u_dut (.*);

  // behavioural reference
  int m_hi[2], m_lo[2], m_hy[2];
  bit m_th[2], m_tl[2], m_sh[2], m_sl[2];
  bit m_en, m_bs;
  int ch, wc, th, tl;
  bit ovr, und;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        m_hi[i] = 4095; m_lo[i] = 0; m_hy[i] = 0;
        m_th[i] = 0; m_tl[i] = 0; m_sh[i] = 0; m_sl[i] = 0;
      end
      m_en = 0; m_bs = 0;
    end else begin
      ch = res_chan; wc = wr_chan;
      if (wr_en && wr_sel == 4) begin
        if (wr_data[0]) m_sh[wc] = 0;
        if (wr_data[1]) m_sl[wc] = 0;
      end
      if (res_valid) begin
        ovr = res_data > m_hi[ch];
        und = res_data < m_lo[ch];
        th = m_hi[ch] - m_hy[ch]; if (th < 0) th = 0;
        tl = m_lo[ch] + m_hy[ch]; if (tl > 4095) tl = 4095;
        if (ovr && !m_th[ch]) m_sh[ch] = 1;
        if (und && !m_tl[ch]) m_sl[ch] = 1;
        if (ovr) m_th[ch] = 1; else if (res_data <= th) m_th[ch] = 0;
        if (und) m_tl[ch] = 1; else if (res_data >= tl) m_tl[ch] = 0;
      end
      if (wr_en) case (wr_sel)
        0: m_hi[wc] = wr_data;
        1: m_lo[wc] = wr_data;
        2: m_hy[wc] = wr_data;
        3: begin m_en = wr_data[0]; m_bs = wr_data[1]; end
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < 2; i++) begin
      chk(stat_hi[i] == m_sh[i], "R2/R5 model stat_hi", stat_hi[i], m_sh[i]);
      chk(stat_lo[i] == m_sl[i], "R3/R6 model stat_lo", stat_lo[i], m_sl[i]);
    end
    chk(alert_n == (m_bs ? !busy_in : !(m_en && (m_sh[0]|m_sh[1]|m_sl[0]|m_sl[1]))),
        "R8/R9 model alert_n", alert_n, m_bs ? !busy_in : !(m_en && (m_sh[0]|m_sh[1]|m_sl[0]|m_sl[1])));
  end

  task automatic cyc(input bit rv, input int rc, input int rd,
                     input bit we, input int ws, input int wch, input int wd);
    res_valid = rv; res_chan = 1'(rc); res_data = 12'(rd);
    wr_en = we; wr_sel = 3'(ws); wr_chan = 1'(wch); wr_data = 12'(wd);
    @(negedge clk); #1;
    res_valid = 0; wr_en = 0;
  endtask

  task automatic res(input int c, input int d); cyc(1, c, d, 0, 0, 0, 0); endtask
  task automatic wr(input int s, input int c, input int d); cyc(0, 0, 0, 1, s, c, d); endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk(stat_hi == 0 && stat_lo == 0 && alert_n, "R1 reset state", {stat_hi, stat_lo, alert_n}, 1);
    res(0, 12'hFFF); res(1, 12'h000);
    chk(stat_hi == 0 && stat_lo == 0, "R1 reset bounds", {stat_hi, stat_lo}, 0);

    wr(3, 0, 1);
    wr(0, 0, 12'h800); wr(1, 0, 12'h100); wr(2, 0, 12'h020);
    res(0, 12'h800);
    chk(stat_hi == 0, "R2 equal high", stat_hi, 0);
    res(0, 12'h801);
    chk(stat_hi == 2'b01, "R2 above high", stat_hi, 1);
    chk(alert_n == 0, "R8 pin low", alert_n, 0);
    chk(stat_hi[1] == 0, "R4 other channel", stat_hi[1], 0);
    wr(4, 0, 1);
    chk(stat_hi == 0 && alert_n, "R7 clear", {stat_hi, alert_n}, 1);
    res(0, 12'h900);
    chk(stat_hi == 0, "R5 tripped no reset", stat_hi, 0);
    res(0, 12'h7F0); res(0, 12'h900);
    chk(stat_hi == 0, "R5 band no rearm", stat_hi, 0);
    res(0, 12'h7E0); res(0, 12'h801);
    chk(stat_hi == 2'b01, "R5 rearm", stat_hi, 1);
    wr(4, 0, 1); res(0, 12'h7E0);
    cyc(1, 0, 12'h900, 1, 4, 0, 1);
    chk(stat_hi == 2'b01, "R7 set wins", stat_hi, 1);
    wr(4, 0, 1);

    res(0, 12'h100);
    chk(stat_lo == 0, "R3 equal low", stat_lo, 0);
    res(0, 12'h0FF);
    chk(stat_lo == 2'b01, "R3 below low", stat_lo, 1);
    wr(4, 0, 2);
    res(0, 12'h050);
    chk(stat_lo == 0, "R6 tripped", stat_lo, 0);
    res(0, 12'h11F); res(0, 12'h050);
    chk(stat_lo == 0, "R6 band no rearm", stat_lo, 0);
    res(0, 12'h120); res(0, 12'h0FF);
    chk(stat_lo == 2'b01, "R6 rearm", stat_lo, 1);

    wr(0, 1, 12'h400); res(1, 12'h401);
    chk(stat_hi == 2'b10 && stat_lo == 2'b01, "R4 channel 1", {stat_hi, stat_lo}, 6'h9);

    wr(3, 0, 0);
    chk(alert_n == 1, "R8 disabled", alert_n, 1);
    res(1, 12'h500);
    wr(3, 0, 2); busy_in = 1; #1;
    chk(alert_n == 0, "R9 busy high", alert_n, 0);
    busy_in = 0; #1;
    chk(alert_n == 1, "R9 busy low", alert_n, 1);
    wr(3, 0, 3);
    chk(alert_n == 1, "R9 ignores flags", alert_n, 1);
    wr(3, 0, 1);

    wr(4, 0, 3); wr(4, 1, 3);
    wr(0, 1, 12'h010); wr(2, 1, 12'h050); res(1, 12'h000);
    res(1, 12'h011);
    chk(stat_hi[1] == 1, "R10 high trip", stat_hi[1], 1);
    wr(4, 1, 1); res(1, 12'h001); res(1, 12'h011);
    chk(stat_hi[1] == 0, "R10 high floor", stat_hi[1], 0);
    res(1, 12'h000); res(1, 12'h011);
    chk(stat_hi[1] == 1, "R10 high rearm at zero", stat_hi[1], 1);
    wr(0, 1, 12'hFFF); wr(1, 1, 12'hFC0); wr(4, 1, 3);
    res(1, 12'hFBF);
    chk(stat_lo[1] == 1, "R10 low trip", stat_lo[1], 1);
    wr(4, 1, 2); res(1, 12'hFFE); res(1, 12'hFBF);
    chk(stat_lo[1] == 0, "R10 low ceiling", stat_lo[1], 0);
    res(1, 12'hFFF); res(1, 12'hFBF);
    chk(stat_lo[1] == 1, "R10 low rearm at max", stat_lo[1], 1);

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule